// File: doc/BRIEF.md
# Alternating Framebuffer Fetch Sequencer

This block produces the burst read requests that move a frame's pixel words from memory into a display FIFO. A frame lives in a region described by a start address and an inclusive last-byte address. The sequencer can either repeat a single region every frame or take two regions in turn, which gives double buffering. It walks each region in word-aligned bursts and shortens the last burst so that no read goes past the region's end. Once the final beat of a region has returned, it raises a per-region end-of-frame flag.

Software may rewrite a region's bounds while the sequencer is fetching, for example after that region's end-of-frame flag. The sequencer copies the bounds when a region's fetch begins, so a rewrite takes effect the next time that region comes round. A request is raised only when the FIFO, counting the words already promised to earlier bursts, has room for the whole burst and for a programmable free-space watermark. A pop from an empty FIFO while the display is active sets a sticky underflow flag.

Top module: `pp_frame_fetch`

## Requirements
- R1: After reset `rd_req` is low and every bit of `stat` is 0.
- R2: Each fetch of a region starts at that region's start address. Each granted burst advances the address by 4 × `rd_len` bytes, and addresses are word aligned. With `dma_ctrl[0]`=0 only region 0 is fetched, frame after frame.
- R3: The last burst of a region is cut to the words left up to the region's inclusive last-byte address. No request reads past that address.
- R4: Field `dma_ctrl[6:4]` gives the burst length. A code n in 0..4 means 2^n beats, and codes 5..7 mean 16 beats.
- R5: With `dma_ctrl[0]`=1 the regions alternate: region 0, then region 1, then region 0 again, and so on.
- R6: When the last beat of region 0 has returned, `stat[8]` sets. Region 1 sets `stat[9]` in the same way. A 1 in `stat_clr` clears the matching bit.
- R7: A rewrite of a region's bounds during that region's fetch does not change the current fetch. The next fetch of that region uses the new bounds.
- R8: No request is raised unless the free FIFO space (depth minus words held minus words outstanding) is at least the burst length.
- R9: Field `dma_ctrl[10:8]` holds a code t. A request also needs free space of at least min(8·2^t, FIFO depth) words.
- R10: `stat[5]` sets when `pix_pop` is asserted with the FIFO empty while `disp_active` is high. The same pop with `disp_active` low leaves it clear.
- R11: Once `rd_req` is raised, it stays high with `rd_addr` and `rd_len` unchanged until `rd_gnt` is seen.
- R12: `cfg_sel` selects the register that `cfg_wr` writes: 0 is the region 0 start, 1 is the region 0 end, 2 is the region 1 start, 3 is the region 1 end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enable fetching; fetching restarts at region 0 |
| dma_ctrl | input | 16 | Mode bit 0, burst code 6:4, watermark code 10:8 |
| cfg_wr | input | 1 | Write strobe for a region bound |
| cfg_sel | input | 2 | Region bound selector |
| cfg_wdata | input | AW | Bound value |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | AW | Burst byte address |
| rd_len | output | 5 | Burst beat count |
| rd_gnt | input | 1 | Request accepted this cycle |
| rd_valid | input | 1 | One data word returned into the FIFO |
| disp_active | input | 1 | Display is in its active area |
| pix_pop | input | 1 | Display takes one word from the FIFO |
| stat | output | 10 | Sticky flags: 5 underflow, 8 region 0 end, 9 region 1 end |
| stat_clr | input | 10 | Write-1-to-clear mask for `stat` |

## Verification
The sequence of granted bursts is recorded for several region shapes. A region that divides evenly into bursts tests plain stepping and wrap to the start. A 20-word region tests the shortened tail, and a two-region setup with unequal sizes tests the alternation order. Every burst code, including an unsupported one, is run, and the length and stride of the first bursts show the decode. With pops held off, the number of grants before the stall separates the room rule from the watermark rule. A rewrite during a stalled fetch shows that the bounds in use were copied when the fetch began.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_LOAD  = 2'd1,
    SQ_REQ   = 2'd2,
    SQ_DRAIN = 2'd3
  } seq_st_e;

  localparam int CTL_ALT_BIT   = 0;
  localparam int CTL_BURST_LSB = 4;
  localparam int CTL_THR_LSB   = 8;
  localparam int STAT_W        = 10;
  localparam int STAT_UFLOW    = 5;
  localparam int STAT_EOF0     = 8;
  localparam int STAT_EOF1     = 9;

  // beats per burst: 2^code, codes above max_log fall back to 2^max_log
  function automatic int unsigned burst_beats(input logic [2:0] code,
                                              input int unsigned max_log);
    if (int'(code) > int'(max_log)) return 32'd1 << max_log;
    return 32'd1 << code;
  endfunction

  // free-space watermark in words, capped at the FIFO depth
  function automatic int unsigned ready_mark(input logic [2:0] code,
                                             input int unsigned depth);
    int unsigned m;
    m = 32'd8 << code;
    return (m > depth) ? depth : m;
  endfunction

endpackage

// File: rtl/pp_region_bank.sv
module pp_region_bank #(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_sel,
  input  logic [AW-1:0]        cfg_wdata,
  output logic [1:0][AW-1:0]   base_q,
  output logic [1:0][AW-1:0]   ceil_q
);
  // cfg_sel[1] picks the region, cfg_sel[0] picks start (0) or end (1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ceil_q <= '0;
    end else if (cfg_wr) begin
      for (int r = 0; r < 2; r++) begin
        if (cfg_sel[1] == 1'(r)) begin
          if (cfg_sel[0]) ceil_q[r] <= cfg_wdata;
          else            base_q[r] <= cfg_wdata;
        end
      end
    end
  end
endmodule

// File: rtl/pp_fifo_credit.sv
module pp_fifo_credit #(
  parameter int DEPTH = 64,
  parameter int LENW  = 5,
  parameter int LVW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant_fire,
  input  logic [LENW-1:0] grant_len,
  input  logic            rd_valid,
  input  logic            pix_pop,
  input  logic            disp_active,
  output logic [LVW-1:0]  level,
  output logic [LVW-1:0]  pending,
  output logic [LVW-1:0]  free_words,
  output logic            uflow_ev
);
  logic pop_ok;

  assign pop_ok     = pix_pop && (level != '0);
  assign uflow_ev   = disp_active && pix_pop && (level == '0);
  assign free_words = LVW'(DEPTH) - level - pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= '0;
      pending <= '0;
    end else begin
      level   <= level + LVW'(rd_valid) - LVW'(pop_ok);
      pending <= pending + (grant_fire ? LVW'(grant_len) : '0) - LVW'(rd_valid);
    end
  end
endmodule

// File: rtl/pp_burst_seq.sv
module pp_burst_seq
  import pp_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LENW    = 5,
  parameter int LVW     = 7,
  parameter int MAX_LOG = 4,
  parameter int DEPTH   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                alt_mode,
  input  logic [2:0]          burst_code,
  input  logic [2:0]          thr_code,
  input  logic [1:0][AW-1:0]  base_q,
  input  logic [1:0][AW-1:0]  ceil_q,
  input  logic [LVW-1:0]      free_words,
  input  logic [LVW-1:0]      pending,
  input  logic                rd_gnt,
  output logic                rd_req,
  output logic [AW-1:0]       rd_addr,
  output logic [LENW-1:0]     rd_len,
  output logic                grant_fire,
  output logic                eof0,
  output logic                eof1,
  output logic [AW-1:0]       cur_ceil
);
  localparam int WW = AW - 2;

  // words from the current address up to and including the end word
  function automatic logic [WW-1:0] words_left(input logic [AW-1:0] a,
                                               input logic [AW-1:0] c);
    return c[AW-1:2] - a[AW-1:2] + WW'(1);
  endfunction

  seq_st_e         st;
  logic            sel;
  logic [AW-1:0]   addr_q;
  logic [LENW-1:0] beats_q;
  logic [LVW-1:0]  mark_q;
  logic [WW-1:0]   left;
  logic            last_burst;
  logic [LVW-1:0]  need;
  logic            frame_done;

  always_comb begin
    left       = words_left(addr_q, cur_ceil);
    last_burst = left <= WW'(beats_q);
    rd_len     = last_burst ? LENW'(left) : beats_q;
    need       = (LVW'(rd_len) > mark_q) ? LVW'(rd_len) : mark_q;
  end

  assign rd_addr    = addr_q;
  assign rd_req     = (st == SQ_REQ) && (free_words >= need);
  assign grant_fire = rd_req && rd_gnt;
  assign frame_done = (st == SQ_DRAIN) && (pending == '0);
  assign eof0       = frame_done && !sel;
  assign eof1       = frame_done && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      sel      <= 1'b0;
      addr_q   <= '0;
      cur_ceil <= '0;
      beats_q  <= '0;
      mark_q   <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (run) begin
          st  <= SQ_LOAD;
          sel <= 1'b0;
        end
        SQ_LOAD: begin
          addr_q   <= base_q[sel];
          cur_ceil <= ceil_q[sel];
          beats_q  <= LENW'(burst_beats(burst_code, MAX_LOG));
          mark_q   <= LVW'(ready_mark(thr_code, DEPTH));
          st       <= SQ_REQ;
        end
        SQ_REQ: begin
          if (grant_fire) begin
            addr_q <= addr_q + (AW'(rd_len) << 2);
            if (last_burst) st <= SQ_DRAIN;
          end else if (!run && !rd_req) begin
            st <= SQ_IDLE;
          end
        end
        SQ_DRAIN: if (pending == '0) begin
          sel <= alt_mode && !sel;
          st  <= run ? SQ_LOAD : SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_frame_fetch.sv
module pp_frame_fetch
  import pp_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FIFO_DEPTH = 64,
  parameter int MAX_LOG    = 4,
  localparam int LENW      = $clog2((1 << MAX_LOG) + 1),
  localparam int LVW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [15:0]       dma_ctrl,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output logic [LENW-1:0]   rd_len,
  input  logic              rd_gnt,
  input  logic              rd_valid,
  input  logic              disp_active,
  input  logic              pix_pop,
  output logic [STAT_W-1:0] stat,
  input  logic [STAT_W-1:0] stat_clr
);
  logic [1:0][AW-1:0] base_q;
  logic [1:0][AW-1:0] ceil_q;
  logic [LVW-1:0]     level;
  logic [LVW-1:0]     pending;
  logic [LVW-1:0]     free_words;
  logic               uflow_ev;
  logic               grant_fire;
  logic               eof0;
  logic               eof1;
  logic [AW-1:0]      cur_ceil;
  logic [STAT_W-1:0]  stat_set;
  logic               unused_ctrl;

  // swap and endian bits belong to pixel unpacking, not to this block
  assign unused_ctrl = ^{dma_ctrl[15:11], dma_ctrl[7], dma_ctrl[3:1], level};

  pp_region_bank #(.AW(AW)) i_bank (
    .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_wdata,
    .base_q, .ceil_q
  );

  pp_fifo_credit #(.DEPTH(FIFO_DEPTH), .LENW(LENW), .LVW(LVW)) i_credit (
    .clk, .rst_n,
    .grant_fire, .grant_len(rd_len),
    .rd_valid, .pix_pop, .disp_active,
    .level, .pending, .free_words, .uflow_ev
  );

  pp_burst_seq #(
    .AW(AW), .LENW(LENW), .LVW(LVW), .MAX_LOG(MAX_LOG), .DEPTH(FIFO_DEPTH)
  ) i_seq (
    .clk, .rst_n, .run,
    .alt_mode  (dma_ctrl[CTL_ALT_BIT]),
    .burst_code(dma_ctrl[CTL_BURST_LSB +: 3]),
    .thr_code  (dma_ctrl[CTL_THR_LSB +: 3]),
    .base_q, .ceil_q, .free_words, .pending, .rd_gnt,
    .rd_req, .rd_addr, .rd_len, .grant_fire, .eof0, .eof1, .cur_ceil
  );

  always_comb begin
    stat_set             = '0;
    stat_set[STAT_UFLOW] = uflow_ev;
    stat_set[STAT_EOF0]  = eof0;
    stat_set[STAT_EOF1]  = eof1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~stat_clr) | stat_set;
  end
endmodule

// File: rtl/pp_frame_fetch_chk.sv
module pp_frame_fetch_chk #(
  parameter int AW   = 32,
  parameter int LENW = 5,
  parameter int LVW  = 7,
  parameter int MAXB = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic            rd_gnt,
  input logic [AW-1:0]   rd_addr,
  input logic [LENW-1:0] rd_len,
  input logic [AW-1:0]   cur_ceil,
  input logic [LVW-1:0]  free_words,
  input logic            eof0,
  input logic            eof1,
  input logic            uflow_ev,
  input logic [9:0]      stat
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr) && $stable(rd_len)); // R11

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00); // R2

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_len != '0) && (int'(rd_len) <= MAXB)); // R4

  AST_NO_PAST_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr + (AW'(rd_len) << 2) - AW'(1) <= cur_ceil); // R3

  AST_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> free_words >= LVW'(rd_len)); // R8

  AST_EOF0_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eof0 |=> stat[8]); // R6

  AST_EOF1_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eof1 |=> stat[9]); // R6

  AST_UFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_ev |=> stat[5]); // R10
endmodule

bind pp_frame_fetch pp_frame_fetch_chk #(
  .AW(AW), .LENW(LENW), .LVW(LVW), .MAXB(1 << MAX_LOG)
) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_gnt(rd_gnt),
  .rd_addr(rd_addr), .rd_len(rd_len), .cur_ceil(cur_ceil),
  .free_words(free_words), .eof0(eof0), .eof1(eof1),
  .uflow_ev(uflow_ev), .stat(stat)
);

// File: tb/test_pp_frame_fetch.sv
`timescale 1ns/1ps
module test_pp_frame_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [15:0] dma_ctrl = '0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic [4:0]  rd_len;
  logic        rd_gnt = 1'b0;
  logic        rd_valid = 1'b0;
  logic        disp_active = 1'b0;
  logic        pix_pop = 1'b0;
  logic [9:0]  stat;
  logic [9:0]  stat_clr = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic gnt_en = 1'b0;
  logic pop_en = 1'b0;
  logic force_pop = 1'b0;
  logic [31:0] g_addr [0:255];
  logic [4:0]  g_len  [0:255];
  int g_n = 0;
  int blevel = 0;
  int ret_cnt = 0;
  int add_nx = 0;

  always #2.5 clk = ~clk;

  pp_frame_fetch i_pp_frame_fetch (
    .clk, .rst_n, .run, .dma_ctrl, .cfg_wr, .cfg_sel, .cfg_wdata,
    .rd_req, .rd_addr, .rd_len, .rd_gnt, .rd_valid,
    .disp_active, .pix_pop, .stat, .stat_clr
  );

  // memory and display model: grants, returns and pops on falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      g_n = 0; blevel = 0; ret_cnt = 0; add_nx = 0;
      rd_gnt = 1'b0; rd_valid = 1'b0; pix_pop = 1'b0;
    end else begin
      if (pix_pop && blevel > 0) blevel--;
      if (rd_valid) blevel++;
      ret_cnt += add_nx;
      add_nx = 0;
      rd_gnt = gnt_en && rd_req;
      if (rd_gnt) begin
        if (g_n < 256) begin
          g_addr[g_n] = rd_addr;
          g_len[g_n]  = rd_len;
        end
        g_n++;
        add_nx = int'(rd_len);
      end
      rd_valid = ret_cnt > 0;
      if (rd_valid) ret_cnt--;
      pix_pop = force_pop || (pop_en && blevel > 0);
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; gnt_en = 1'b0; pop_en = 1'b0; force_pop = 1'b0;
    disp_active = 1'b0; stat_clr = '0; cfg_wr = 1'b0; dma_ctrl = '0;
    settle(3);
    rst_n = 1'b1;
    settle(1);
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input logic alt, input logic [2:0] b, input logic [2:0] t);
    return {5'b0, t, 1'b0, b, 3'b0, alt};
  endfunction

  task automatic wait_grants(input int n);
    int k = 0;
    while (g_n < n && k < 5000) begin
      settle(1);
      k++;
    end
  endtask

  task automatic stop_and_idle();
    run = 1'b0;
    settle(150);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rd_req", 32'(rd_req), 32'd0);
    check("R1 stat", 32'(stat), 32'd0);
  endtask

  task automatic t_single_region();
    do_reset();
    wr_cfg(2'd0, 32'h1000);
    wr_cfg(2'd1, 32'h103F);
    dma_ctrl = ctl(1'b0, 3'd3, 3'd0);
    gnt_en = 1'b1; pop_en = 1'b1; run = 1'b1;
    wait_grants(5);
    check("R2 addr0", g_addr[0], 32'h1000);
    check("R2 len0", 32'(g_len[0]), 32'd8);
    check("R2 addr1", g_addr[1], 32'h1020);
    check("R2 wrap addr2", g_addr[2], 32'h1000);
    check("R2 addr4", g_addr[4], 32'h1000);
    check("R6 eof0 set", 32'(stat[8]), 32'd1);
    check("R2 no region1", 32'(stat[9]), 32'd0);
    stop_and_idle();
    stat_clr = 10'h100;
    settle(1);
    stat_clr = '0;
    settle(1);
    check("R6 eof0 cleared", 32'(stat[8]), 32'd0);
  endtask

  task automatic t_short_tail();
    do_reset();
    wr_cfg(2'd0, 32'h4000);
    wr_cfg(2'd1, 32'h404F);
    dma_ctrl = ctl(1'b0, 3'd3, 3'd0);
    gnt_en = 1'b1; pop_en = 1'b1; run = 1'b1;
    wait_grants(4);
    check("R3 tail addr", g_addr[2], 32'h4040);
    check("R3 tail len", 32'(g_len[2]), 32'd4);
    check("R3 restart", g_addr[3], 32'h4000);
    check("R3 full len", 32'(g_len[3]), 32'd8);
    stop_and_idle();
  endtask

  task automatic t_burst_code(input logic [2:0] code, input int exp_len);
    do_reset();
    wr_cfg(2'd0, 32'h6000);
    wr_cfg(2'd1, 32'h60FF);
    dma_ctrl = ctl(1'b0, code, 3'd0);
    gnt_en = 1'b1; pop_en = 1'b1; run = 1'b1;
    wait_grants(2);
    check($sformatf("R4 len code %0d", code), 32'(g_len[0]), 32'(exp_len));
    check($sformatf("R4 stride code %0d", code), g_addr[1], 32'h6000 + 32'(exp_len * 4));
    stop_and_idle();
  endtask

  task automatic t_alternate();
    do_reset();
    wr_cfg(2'd0, 32'h1000);
    wr_cfg(2'd1, 32'h101F);
    wr_cfg(2'd2, 32'h2000);
    wr_cfg(2'd3, 32'h200F);
    dma_ctrl = ctl(1'b1, 3'd4, 3'd0);
    gnt_en = 1'b1; pop_en = 1'b1; run = 1'b1;
    wait_grants(4);
    check("R5 first r0", g_addr[0], 32'h1000);
    check("R5 r0 len", 32'(g_len[0]), 32'd8);
    check("R5 then r1 R12", g_addr[1], 32'h2000);
    check("R5 r1 len", 32'(g_len[1]), 32'd4);
    check("R5 back r0", g_addr[2], 32'h1000);
    check("R5 r1 again", g_addr[3], 32'h2000);
    stop_and_idle();
    check("R6 eof1 set", 32'(stat[9]), 32'd1);
    stat_clr = 10'h200;
    settle(1);
    stat_clr = '0;
    settle(1);
    check("R6 eof1 cleared", 32'(stat[9]), 32'd0);
    check("R6 eof0 kept", 32'(stat[8]), 32'd1);
  endtask

  task automatic t_reload_and_room();
    do_reset();
    wr_cfg(2'd0, 32'h8000);
    wr_cfg(2'd1, 32'h81FF);
    dma_ctrl = ctl(1'b0, 3'd4, 3'd0);
    gnt_en = 1'b1; pop_en = 1'b0; run = 1'b1;
    settle(200);
    check("R8 grants before stall", 32'(g_n), 32'd4);
    check("R8 no request when full", 32'(rd_req), 32'd0);
    wr_cfg(2'd0, 32'h9000);
    wr_cfg(2'd1, 32'h903F);
    pop_en = 1'b1;
    wait_grants(10);
    check("R7 old bounds kept", g_addr[4], 32'h8100);
    check("R7 old last", g_addr[7], 32'h81C0);
    check("R7 new start", g_addr[8], 32'h9000);
    check("R7 new end wraps", g_addr[9], 32'h9000);
    stop_and_idle();
  endtask

  task automatic t_hold();
    logic [31:0] a0;
    logic [4:0]  l0;
    do_reset();
    wr_cfg(2'd0, 32'h3000);
    wr_cfg(2'd1, 32'h30FF);
    dma_ctrl = ctl(1'b0, 3'd2, 3'd0);
    gnt_en = 1'b0; run = 1'b1;
    settle(10);
    a0 = rd_addr; l0 = rd_len;
    check("R11 req raised", 32'(rd_req), 32'd1);
    settle(20);
    check("R11 req held", 32'(rd_req), 32'd1);
    check("R11 addr held", rd_addr, a0);
    check("R11 len held", 32'(rd_len), 32'(l0));
    gnt_en = 1'b1; pop_en = 1'b1;
    stop_and_idle();
  endtask

  task automatic t_watermark();
    do_reset();
    wr_cfg(2'd0, 32'hA000);
    wr_cfg(2'd1, 32'hA1FF);
    dma_ctrl = ctl(1'b0, 3'd0, 3'd2);
    gnt_en = 1'b1; pop_en = 1'b0; run = 1'b1;
    settle(300);
    check("R9 grants to watermark", 32'(g_n), 32'd33);
    check("R9 stalled", 32'(rd_req), 32'd0);
    pop_en = 1'b1;
    stop_and_idle();
  endtask

  task automatic t_underflow();
    do_reset();
    disp_active = 1'b0;
    @(negedge clk); force_pop = 1'b1;
    @(negedge clk); force_pop = 1'b0;
    settle(2);
    check("R10 inactive no flag", 32'(stat[5]), 32'd0);
    disp_active = 1'b1;
    @(negedge clk); force_pop = 1'b1;
    @(negedge clk); force_pop = 1'b0;
    settle(2);
    check("R10 flag set", 32'(stat[5]), 32'd1);
    disp_active = 1'b0;
    stat_clr = 10'h020;
    settle(1);
    stat_clr = '0;
    settle(1);
    check("R10 flag cleared", 32'(stat[5]), 32'd0);
  endtask

  initial begin
    t_reset();
    t_single_region();
    t_short_tail();
    t_burst_code(3'd0, 1);
    t_burst_code(3'd2, 4);
    t_burst_code(3'd4, 16);
    t_burst_code(3'd7, 16);
    t_alternate();
    t_reload_and_room();
    t_hold();
    t_watermark();
    t_underflow();
    summary();
    $finish;
  end
endmodule